// File: doc/BRIEF.md
# Eight-Channel Converter Command Register File

This block sits behind a serial deserializer and in front of an eight-channel digital-to-analog converter core. Each accepted 16-bit command word carries an address in its upper four bits and a 12-bit payload in its lower twelve bits. The block holds a staging (holding) register and an output latch for each channel, two configuration registers and a preset register. It drives the channel codes and the configuration flags that the analog side uses.

Channel writes, paired writes and preset writes pass through a format stage. This stage can turn a two's-complement payload into offset-binary. It also forces the payload bits below the configured resolution to zero. A paired write loads an even channel with the value and the odd channel next to it with the bitwise inverse. A level-sensitive load input moves the staged values into the output latches, so all channels can change together. An active-low preset input overrides every channel output with the preset register, with no clock involved.

Top module: `dac_regfile_ctrl`

## Requirements
- R1: A word is taken on a rising clock edge while `cmd_valid_i` is high. Bits 15:12 are the address and bits 11:0 are the payload. Addresses 0 to 7 write the holding register of channel 0 to 7.
- R2: Address 8 writes configuration register 0. Payload bit 4 drives `global_pd_o`, bit 3 drives `cascade_en_o`, bits 2:1 drive `ref_sel_o` (0 and 1 external, 2 internal low, 3 internal high) and bit 0 selects the input format. The outputs change one cycle after the write.
- R3: Address 9 writes configuration register 1. Payload bits 7:4 drive `pair_pd_o[3:0]` and bits 3:0 drive `pair_fast_o[3:0]`. Index 0 is pair 0/1 and index 3 is pair 6/7.
- R4: A word with address 11 changes no register and no output.
- R5: Addresses 12 to 15 select pair k = address-12. Channel 2k receives the formatted value and channel 2k+1 receives its bitwise inverse, restricted to the active resolution bits.
- R6: When `load_ni` is low at a clock edge, every output latch takes its holding register's new value, including a write at that same edge. When `load_ni` is high, the output latches keep their values.
- R7: Address 10 writes the preset register with the formatted payload. While `preset_ni` is low, every channel code shows the preset register at once, with no clock edge.
- R8: While format bit 0 of configuration register 0 is 1, payload bit 11 is inverted before it is stored. The format in force is the one held before the current word.
- R9: With resolution parameter `RES_BITS` (8, 10 or 12), the lowest 12-`RES_BITS` bits of every stored code are zero.
- R10: After reset, every latch, register and output is zero.

Top module port order follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid_i | input | 1 | Command word valid |
| cmd_word_i | input | 16 | Address (15:12) and payload (11:0) |
| load_ni | input | 1 | Active-low level-sensitive transfer to output latches |
| preset_ni | input | 1 | Active-low asynchronous preset override |
| chan_code_o | output | 96 | Eight 12-bit codes, channel n at bits n*12 +: 12 |
| pair_pd_o | output | 4 | Per-pair power-down flags |
| pair_fast_o | output | 4 | Per-pair fast-settling flags |
| global_pd_o | output | 1 | Global power-down flag |
| ref_sel_o | output | 2 | Reference select |
| cascade_en_o | output | 1 | Cascade output enable |

## Verification
The assertions take `cmd_valid_i`, `cmd_word_i` and `load_ni` as synchronous to the clock and free of unknown values. They take `preset_ni` as asynchronous, and hold the override check to its state at the sampling edge. The stimulus changes every input only on the falling clock edge. The exception is the preset input, which is also toggled mid-cycle to check that the override needs no clock. No command is issued until the internal reset release has completed.

// File: rtl/dacrf_pkg.sv
package dacrf_pkg;
  localparam int NUM_CH   = 8;
  localparam int NUM_PAIR = NUM_CH / 2;
  localparam int ADDR_W   = 4;
  localparam int CODE_W   = 12;
  localparam int WORD_W   = ADDR_W + CODE_W;
  localparam int CFG0_W   = 5;
  localparam int CFG1_W   = 2 * NUM_PAIR;
  localparam int CH_IDX_W = $clog2(NUM_CH);
  localparam int PAIR_W   = $clog2(NUM_PAIR);

  localparam logic [ADDR_W-1:0] ADR_CFG0   = 4'd8;
  localparam logic [ADDR_W-1:0] ADR_CFG1   = 4'd9;
  localparam logic [ADDR_W-1:0] ADR_PRESET = 4'd10;
  localparam logic [ADDR_W-1:0] ADR_RSVD   = 4'd11;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [CODE_W-1:0] payload;
  } cmd_t;

  typedef logic [CODE_W-1:0] code_t;

  function automatic code_t res_mask(input int res);
    return {CODE_W{1'b1}} << (CODE_W - res);
  endfunction
endpackage

// File: rtl/dacrf_rst_sync.sv
module dacrf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/dacrf_decode.sv
module dacrf_decode
  import dacrf_pkg::*;
#(
  parameter int RES_BITS = 12
) (
  input  logic                           cmd_valid_i,
  input  logic [WORD_W-1:0]              cmd_word_i,
  input  logic                           twos_fmt_i,
  output logic [NUM_CH-1:0]              hold_we_o,
  output logic [NUM_CH-1:0][CODE_W-1:0]  hold_wdata_o,
  output logic                           cfg0_we_o,
  output logic                           cfg1_we_o,
  output logic                           preset_we_o,
  output logic [CFG0_W-1:0]              cfg0_data_o,
  output logic [CFG1_W-1:0]              cfg1_data_o,
  output logic [CODE_W-1:0]              preset_data_o
);
  localparam code_t MASK    = res_mask(RES_BITS);
  localparam code_t MSB_BIT = code_t'(1) << (CODE_W - 1);

  cmd_t              cmd;
  code_t             conv;
  code_t             conv_inv;
  logic              is_chan;
  logic              is_pair;
  logic [PAIR_W-1:0] pair_sel;

  always_comb begin
    cmd      = cmd_t'(cmd_word_i);
    conv     = (twos_fmt_i ? (cmd.payload ^ MSB_BIT) : cmd.payload) & MASK;
    conv_inv = ~conv & MASK;
    is_chan  = cmd_valid_i && !cmd.addr[ADDR_W-1];
    is_pair  = cmd_valid_i && (cmd.addr[ADDR_W-1 -: 2] == 2'b11);
    pair_sel = cmd.addr[PAIR_W-1:0];
  end

  always_comb begin
    for (int ch = 0; ch < NUM_CH; ch++) begin
      hold_we_o[ch]    = 1'b0;
      hold_wdata_o[ch] = conv;
      if (is_chan && (cmd.addr[CH_IDX_W-1:0] == CH_IDX_W'(ch))) begin
        hold_we_o[ch] = 1'b1;
      end
      if (is_pair && (pair_sel == PAIR_W'(ch / 2))) begin
        hold_we_o[ch] = 1'b1;
        if ((ch % 2) == 1) hold_wdata_o[ch] = conv_inv;
      end
    end
  end

  always_comb begin
    cfg0_we_o   = cmd_valid_i && (cmd.addr == ADR_CFG0);
    cfg1_we_o   = cmd_valid_i && (cmd.addr == ADR_CFG1);
    preset_we_o = cmd_valid_i && (cmd.addr == ADR_PRESET);
    cfg0_data_o   = cmd.payload[CFG0_W-1:0];
    cfg1_data_o   = cmd.payload[CFG1_W-1:0];
    preset_data_o = conv;
  end
endmodule

// File: rtl/dacrf_chan_bank.sv
module dacrf_chan_bank
  import dacrf_pkg::*;
(
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_CH-1:0]             hold_we_i,
  input  logic [NUM_CH-1:0][CODE_W-1:0] hold_wdata_i,
  input  logic                          load_ni,
  output logic [NUM_CH-1:0][CODE_W-1:0] hold_q_o,
  output logic [NUM_CH-1:0][CODE_W-1:0] out_q_o
);
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    code_t hold_q, hold_d;
    code_t out_q,  out_d;
    logic  out_en;

    always_comb begin
      hold_d = hold_we_i[ch] ? hold_wdata_i[ch] : hold_q;
      out_en = !load_ni;
      out_d  = out_en ? hold_d : out_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hold_q <= '0;
        out_q  <= '0;
      end else begin
        hold_q <= hold_d;
        out_q  <= out_d;
      end
    end

    assign hold_q_o[ch] = hold_q;
    assign out_q_o[ch]  = out_q;
  end
endmodule

// File: rtl/dacrf_cfg_regs.sv
module dacrf_cfg_regs
  import dacrf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg0_we_i,
  input  logic              cfg1_we_i,
  input  logic              preset_we_i,
  input  logic [CFG0_W-1:0] cfg0_data_i,
  input  logic [CFG1_W-1:0] cfg1_data_i,
  input  logic [CODE_W-1:0] preset_data_i,
  output logic [CFG0_W-1:0] cfg0_q_o,
  output logic [CFG1_W-1:0] cfg1_q_o,
  output logic [CODE_W-1:0] preset_q_o
);
  logic [CFG0_W-1:0] cfg0_q, cfg0_d;
  logic [CFG1_W-1:0] cfg1_q, cfg1_d;
  code_t             preset_q, preset_d;

  always_comb begin
    cfg0_d   = cfg0_we_i   ? cfg0_data_i   : cfg0_q;
    cfg1_d   = cfg1_we_i   ? cfg1_data_i   : cfg1_q;
    preset_d = preset_we_i ? preset_data_i : preset_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg0_q   <= '0;
      cfg1_q   <= '0;
      preset_q <= '0;
    end else begin
      cfg0_q   <= cfg0_d;
      cfg1_q   <= cfg1_d;
      preset_q <= preset_d;
    end
  end

  assign cfg0_q_o   = cfg0_q;
  assign cfg1_q_o   = cfg1_q;
  assign preset_q_o = preset_q;
endmodule

// File: rtl/dac_regfile_ctrl.sv
module dac_regfile_ctrl
  import dacrf_pkg::*;
#(
  parameter int RES_BITS = 12
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cmd_valid_i,
  input  logic [WORD_W-1:0]        cmd_word_i,
  input  logic                     load_ni,
  input  logic                     preset_ni,
  output logic [NUM_CH*CODE_W-1:0] chan_code_o,
  output logic [NUM_PAIR-1:0]      pair_pd_o,
  output logic [NUM_PAIR-1:0]      pair_fast_o,
  output logic                     global_pd_o,
  output logic [1:0]               ref_sel_o,
  output logic                     cascade_en_o
);
  logic                          rst_sync_n;
  logic [NUM_CH-1:0]             hold_we;
  logic [NUM_CH-1:0][CODE_W-1:0] hold_wdata;
  logic [NUM_CH-1:0][CODE_W-1:0] hold_q;
  logic [NUM_CH-1:0][CODE_W-1:0] out_q;
  logic                          cfg0_we, cfg1_we, preset_we;
  logic [CFG0_W-1:0]             cfg0_data, cfg0_q;
  logic [CFG1_W-1:0]             cfg1_data, cfg1_q;
  code_t                         preset_data, preset_q;
  logic                          twos_fmt;

  dacrf_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  dacrf_decode #(.RES_BITS(RES_BITS)) u_decode (
    .cmd_valid_i   (cmd_valid_i),
    .cmd_word_i    (cmd_word_i),
    .twos_fmt_i    (twos_fmt),
    .hold_we_o     (hold_we),
    .hold_wdata_o  (hold_wdata),
    .cfg0_we_o     (cfg0_we),
    .cfg1_we_o     (cfg1_we),
    .preset_we_o   (preset_we),
    .cfg0_data_o   (cfg0_data),
    .cfg1_data_o   (cfg1_data),
    .preset_data_o (preset_data)
  );

  dacrf_chan_bank u_bank (
    .clk_i        (clk_i),
    .rst_ni       (rst_sync_n),
    .hold_we_i    (hold_we),
    .hold_wdata_i (hold_wdata),
    .load_ni      (load_ni),
    .hold_q_o     (hold_q),
    .out_q_o      (out_q)
  );

  dacrf_cfg_regs u_cfg (
    .clk_i         (clk_i),
    .rst_ni        (rst_sync_n),
    .cfg0_we_i     (cfg0_we),
    .cfg1_we_i     (cfg1_we),
    .preset_we_i   (preset_we),
    .cfg0_data_i   (cfg0_data),
    .cfg1_data_i   (cfg1_data),
    .preset_data_i (preset_data),
    .cfg0_q_o      (cfg0_q),
    .cfg1_q_o      (cfg1_q),
    .preset_q_o    (preset_q)
  );

  assign twos_fmt     = cfg0_q[0];
  assign ref_sel_o    = cfg0_q[2:1];
  assign cascade_en_o = cfg0_q[3];
  assign global_pd_o  = cfg0_q[4];
  assign pair_fast_o  = cfg1_q[NUM_PAIR-1:0];
  assign pair_pd_o    = cfg1_q[CFG1_W-1:NUM_PAIR];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_out
    assign chan_code_o[ch*CODE_W +: CODE_W] = preset_ni ? out_q[ch] : preset_q;
  end
endmodule

// File: rtl/dacrf_checker.sv
module dacrf_checker
  import dacrf_pkg::*;
#(
  parameter int RES_BITS = 12
) (
  input logic                          clk_i,
  input logic                          rst_n,
  input logic                          cmd_valid_i,
  input logic [WORD_W-1:0]             cmd_word_i,
  input logic                          load_ni,
  input logic                          preset_ni,
  input logic [NUM_CH-1:0][CODE_W-1:0] hold_q,
  input logic [NUM_CH-1:0][CODE_W-1:0] out_q,
  input logic [CODE_W-1:0]             preset_q,
  input logic [NUM_CH*CODE_W-1:0]      chan_code_o,
  input logic [NUM_PAIR-1:0]           pair_pd_o,
  input logic [NUM_PAIR-1:0]           pair_fast_o,
  input logic                          global_pd_o,
  input logic [1:0]                    ref_sel_o,
  input logic                          cascade_en_o
);
  localparam code_t MASK = res_mask(RES_BITS);

  logic [2*NUM_PAIR+4-1:0] cfg_view;
  assign cfg_view = {pair_pd_o, pair_fast_o, global_pd_o, ref_sel_o, cascade_en_o};

  AST_RSVD_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_n)
    (cmd_valid_i && cmd_word_i[15:12] == ADR_RSVD) |=> ($stable(hold_q) && $stable(cfg_view) && $stable(preset_q))); // R4

  AST_PAIR_INVERSE: assert property (@(posedge clk_i) disable iff (!rst_n)
    (cmd_valid_i && cmd_word_i[15:14] == 2'b11) |=>
      ((hold_q[{$past(cmd_word_i[13:12]), 1'b0}] ^ hold_q[{$past(cmd_word_i[13:12]), 1'b1}]) == MASK)); // R5

  AST_LOAD_HIGH_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_n)
    load_ni |=> $stable(out_q)); // R6

  AST_LOAD_LOW_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_n)
    !load_ni |=> (out_q == hold_q)); // R6

  AST_PRESET_OVERRIDE: assert property (@(posedge clk_i) disable iff (!rst_n)
    !preset_ni |-> (chan_code_o == {NUM_CH{preset_q}})); // R7

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_mask
    AST_RES_LOW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_n)
      ((hold_q[ch] & ~MASK) == '0) && ((out_q[ch] & ~MASK) == '0)); // R9
  end
endmodule

bind dac_regfile_ctrl dacrf_checker #(.RES_BITS(RES_BITS)) u_chk (
  .clk_i        (clk_i),
  .rst_n        (rst_sync_n),
  .cmd_valid_i  (cmd_valid_i),
  .cmd_word_i   (cmd_word_i),
  .load_ni      (load_ni),
  .preset_ni    (preset_ni),
  .hold_q       (hold_q),
  .out_q        (out_q),
  .preset_q     (preset_q),
  .chan_code_o  (chan_code_o),
  .pair_pd_o    (pair_pd_o),
  .pair_fast_o  (pair_fast_o),
  .global_pd_o  (global_pd_o),
  .ref_sel_o    (ref_sel_o),
  .cascade_en_o (cascade_en_o)
);

// File: tb/dac_regfile_ctrl_bench.sv
`timescale 1ns/1ps
module dac_regfile_ctrl_bench;
  localparam int RES = 10;
  localparam int MASK = 4095 & ~((1 << (12 - RES)) - 1);

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [15:0] cmd_word;
  logic        load_n;
  logic        preset_n;
  logic [95:0] chan_code;
  logic [3:0]  pair_pd, pair_fast;
  logic        global_pd, cascade_en;
  logic [1:0]  ref_sel;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int m_hold[8];
  int m_out[8];
  int m_c0, m_c1, m_pre;

  always #2.5 clk = ~clk;

  dac_regfile_ctrl #(.RES_BITS(RES)) u_dac_regfile_ctrl (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .cmd_valid_i  (cmd_valid),
    .cmd_word_i   (cmd_word),
    .load_ni      (load_n),
    .preset_ni    (preset_n),
    .chan_code_o  (chan_code),
    .pair_pd_o    (pair_pd),
    .pair_fast_o  (pair_fast),
    .global_pd_o  (global_pd),
    .ref_sel_o    (ref_sel),
    .cascade_en_o (cascade_en)
  );

  task automatic check(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  function automatic int fmt(int p);
    int v = p;
    if (m_c0 & 1) v = v ^ 2048;
    return v & MASK;
  endfunction

  task automatic model_edge(bit v, int w, bit ld);
    int a = (w >> 12) & 15;
    int p = w & 4095;
    int nh[8];
    for (int i = 0; i < 8; i++) nh[i] = m_hold[i];
    if (v) begin
      if (a < 8) nh[a] = fmt(p);
      else if (a >= 12) begin
        nh[2*(a-12)]   = fmt(p);
        nh[2*(a-12)+1] = (~fmt(p)) & MASK;
      end else if (a == 10) m_pre = fmt(p);
      else if (a == 8) m_c0 = p & 31;
      else if (a == 9) m_c1 = p & 255;
    end
    for (int i = 0; i < 8; i++) begin
      m_hold[i] = nh[i];
      if (!ld) m_out[i] = nh[i];
    end
  endtask

  task automatic compare_all(string tag);
    for (int ch = 0; ch < 8; ch++)
      check(tag, int'(chan_code[ch*12 +: 12]), preset_n ? m_out[ch] : m_pre);
    check({tag, "/R2"}, int'({global_pd, cascade_en, ref_sel}), m_c0 >> 1);
    check({tag, "/R3"}, int'({pair_pd, pair_fast}), m_c1);
  endtask

  task automatic step(bit v, int w, bit ld, bit pr, string tag);
    cmd_valid = v; cmd_word = w[15:0]; load_n = ld; preset_n = pr;
    @(posedge clk);
    model_edge(v, w, ld);
    @(negedge clk);
    compare_all(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_word = '0; load_n = 1'b1; preset_n = 1'b1;
    for (int i = 0; i < 8; i++) begin m_hold[i] = 0; m_out[i] = 0; end
    m_c0 = 0; m_c1 = 0; m_pre = 0;
    repeat (3) @(negedge clk);
    compare_all("R10 reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    compare_all("R10 after release");

    // R1/R9: channel 2 write, load low, low bits masked (0x5A7 -> 0x5A4)
    step(1, 16'h25A7, 0, 1, "R1");
    check("R9 mask", int'(chan_code[2*12 +: 12]), 'h5A4);
    // R6: load high keeps outputs while holding changes
    step(1, 16'h3123, 1, 1, "R6 hold");
    check("R6 latched", int'(chan_code[3*12 +: 12]), 0);
    step(0, 0, 0, 1, "R6 transfer");
    check("R6 transferred", int'(chan_code[3*12 +: 12]), 'h120);
    // R5: pair 0 write 0x123 -> ch0 0x120, ch1 0xEDC
    step(1, 16'hC123, 0, 1, "R5");
    check("R5 first", int'(chan_code[0 +: 12]), 'h120);
    check("R5 second", int'(chan_code[12 +: 12]), 'hEDC);
    // R2/R3 configuration
    step(1, 16'h801E, 0, 1, "R2");
    check("R2 fields", int'({global_pd, cascade_en, ref_sel}), 'hF);
    step(1, 16'h90A5, 0, 1, "R3");
    check("R3 pd", int'(pair_pd), 'hA);
    check("R3 fast", int'(pair_fast), 'h5);
    // R4: reserved address
    step(1, 16'hBFFF, 0, 1, "R4");
    check("R4 cfg", int'(pair_pd), 'hA);
    // R8: two's complement, channel 4 zero payload -> 0x800
    step(1, 16'h8001, 0, 1, "R8 set");
    step(1, 16'h4000, 0, 1, "R8");
    check("R8 offset", int'(chan_code[4*12 +: 12]), 'h800);
    // R7: preset 0x3FF in two's complement -> 0xBFC, async override
    step(1, 16'hA3FF, 0, 1, "R7 write");
    #1 preset_n = 1'b0;
    #0.5 check("R7 async", int'(chan_code[5*12 +: 12]), 'hBFC);
    @(negedge clk);
    compare_all("R7 held");
    preset_n = 1'b1;
    #0.5 check("R7 release", int'(chan_code[4*12 +: 12]), 'h800);
    @(negedge clk);

    for (int n = 0; n < 3000; n++) begin
      step(($urandom % 4) != 0, int'($urandom % 65536), ($urandom % 10) < 3,
           ($urandom % 10) != 0, "R1 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule